// File: doc/BRIEF.md
# Register bank restore sequencer

This block runs the multi-cycle "restore saved registers" operation of a simple in-order pipeline. A mode bit is captured when the operation issues, and it selects one of two paths.

- **Bank path (mode 0):** the saved values are copied from an internal register bank into the register file. This takes a fixed run of execute cycles and never touches memory.
- **Stack path (mode 1):** the block spends one execute cycle, then pops one word per cycle from a stack in memory for a run of consecutive memory cycles, then spends one final write-back cycle. The read words go into the register file, and the stack pointer is advanced past the popped area.

While either path runs, the block holds a stall toward the decode stage, so the following instruction cannot issue beside it.

The register bank is read through narrow combinational read ports, one per register-file write lane. The number of lanes is the register count divided by the execute-cycle count, rounded up. Memory reads are assumed to return their data in the cycle after the request.

Top module: `regbank_restore_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy`, `stall`, `done`, `mem_req`, `sp_we` and every `rf_we` bit are low. This holds even if a restore was in progress.
- R2: A restore is accepted when `start` is high while idle. The value of `mode` at that edge selects the path: 0 is the bank path and 1 is the stack path.
- R3: On the bank path, `busy` is high for exactly 9 cycles, starting in the cycle after acceptance. `mem_req` stays low for the whole sequence.
- R4: On the bank path, the write lanes are numbered 0 to 2. In execute cycle k (counted from 0), lane j reads bank entry 3k+j on its `bank_ridx` slice and writes that value to register 3k+j. A lane does this only while 3k+j is below 19. Every register from 0 to 18 is written exactly once, in rising order.
- R5: On the stack path, `busy` is high for exactly 21 cycles: one execute cycle, then 19 memory cycles, then one write-back cycle.
- R6: On the stack path, `mem_req` is high in busy cycles 2 to 20 (counting the first busy cycle as 1). The address of request i is the latched stack pointer plus 4·i.
- R7: On the stack path, the word returned in the cycle after request i is written to register i on lane 0 in that same cycle. Lanes 1 and 2 stay idle.
- R8: In the last cycle of the stack path, `sp_we` pulses for one cycle with `sp_wdata` equal to the latched stack pointer plus 76. The bank path never raises `sp_we`.
- R9: `stall` equals `busy` in every cycle. A `start` that arrives while busy is ignored: it neither restarts nor lengthens the sequence.
- R10: `mode` and `sp_in` are sampled only at acceptance. Changing them during a sequence does not affect its path, its addresses or the final stack pointer.
- R11: `done` is a single-cycle pulse in the last busy cycle of either path, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue request for a restore |
| mode | input | 1 | Path select at issue: 0 bank, 1 stack |
| sp_in | input | ADDR_W | Stack pointer at issue |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a request |
| bank_rdata | input | LANES*DATA_W | Bank read data, one slice per lane |
| bank_ridx | output | LANES*IDX_W | Bank read index, one slice per lane |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| rf_we | output | LANES | Register-file write enable per lane |
| rf_waddr | output | LANES*IDX_W | Register-file write index per lane |
| rf_wdata | output | LANES*DATA_W | Register-file write data per lane |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | ADDR_W | New stack pointer |
| busy | output | 1 | Sequence in progress |
| stall | output | 1 | Hold for the next instruction's decode |
| done | output | 1 | Last cycle of the sequence |

## Verification
The bench builds the block with its default parameters: 19 registers, 9 bank execute cycles, and 32-bit data and addresses. These values give three write lanes. The bank copy therefore finishes in its seventh cycle with only lane 0 active, which leaves two empty execute cycles before `done`; the bench checks both the partial last lane cycle and the idle tail. One stack pointer is placed near the top of the address space, so the address run and the final stack pointer wrap around. A reset in the middle of a stack restore exercises the abort return to idle.

// File: rtl/rbr_pkg.sv
// Shared types of the register bank restore sequencer.
package rbr_pkg;

    // Sequencer phase; the bank and stack paths use disjoint phases.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_BANK = 3'd1,
        PH_SEXE = 3'd2,
        PH_SMEM = 3'd3,
        PH_SWB  = 3'd4
    } phase_e;

endpackage

// File: rtl/rbr_ctrl.sv
// Phase controller. It accepts a restore when idle, picks the path from the
// mode bit at that edge and walks the phases with a step counter.
// Assumes: BANK_EX >= 1, NREG >= 2, CNT_W wide enough for both run lengths.
module rbr_ctrl
    import rbr_pkg::*;
#(
    parameter int NREG    = 19,
    parameter int BANK_EX = 9,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    output phase_e           phase,
    output logic [CNT_W-1:0] step,
    output logic             accept,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] BANK_LAST = CNT_W'(BANK_EX - 1);
    localparam logic [CNT_W-1:0] MEM_LAST  = CNT_W'(NREG - 1);

    // Acceptance, occupancy and end-of-sequence decode.
    always_comb begin
        accept = start && (phase == PH_IDLE);
        busy   = (phase != PH_IDLE);
        done   = ((phase == PH_BANK) && (step == BANK_LAST)) || (phase == PH_SWB);
    end

    // Phase and step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    step <= '0;
                    if (start) phase <= mode ? PH_SEXE : PH_BANK;
                end
                PH_BANK: begin
                    if (step == BANK_LAST) begin
                        phase <= PH_IDLE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                PH_SEXE: begin
                    phase <= PH_SMEM;
                    step  <= '0;
                end
                PH_SMEM: begin
                    if (step == MEM_LAST) begin
                        phase <= PH_SWB;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    step  <= '0;
                end
            endcase
        end
    end

    // R11: the sequence ends right after done.
    a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9: an accepted sequence is not cut short before done.
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: the bank step never exceeds the execute window.
    a_r3_bank_window: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BANK) |-> (step <= BANK_LAST));

endmodule

// File: rtl/rbr_stack_agu.sv
// Stack address generator. It latches the stack pointer at acceptance,
// issues one word read per memory-phase cycle at rising addresses and
// tracks the returning word for the register-file write.
// Assumes: read data is valid exactly one cycle after a request.
module rbr_stack_agu
    import rbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 19,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] sp_in,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  step,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] sp_next
);

    localparam int                STEP_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(NREG * STEP_BYTES);

    logic [ADDR_W-1:0] base_q;

    // Base capture at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (accept) base_q <= sp_in;
    end

    // Request, address and final pointer.
    always_comb begin
        mem_req  = (phase == PH_SMEM);
        mem_addr = base_q + ADDR_W'(step) * STRIDE;
        sp_next  = base_q + SPAN;
    end

    // Track the word that returns in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_idx   <= '0;
        end else begin
            wr_valid <= mem_req;
            wr_idx   <= step[IDX_W-1:0];
        end
    end

    // R6: consecutive requests step by one word.
    a_r6_addr_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + STRIDE));

    // R7: every request is followed by a write of its word.
    a_r7_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> wr_valid);

    // R10: the base does not move during the memory phase.
    a_r10_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(base_q));

endmodule

// File: rtl/rbr_bank_copy.sv
// Bank copy lanes. In each bank execute cycle every lane reads one bank
// entry and writes it to the register of the same number, until all
// NREG entries are copied.
// Assumes: LANES * BANK_EX >= NREG (set by the top).
module rbr_bank_copy
    import rbr_pkg::*;
#(
    parameter int NREG   = 19,
    parameter int LANES  = 3,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5,
    parameter int DATA_W = 32
) (
    input  phase_e                   phase,
    input  logic [CNT_W-1:0]         step,
    input  logic [LANES*DATA_W-1:0]  bank_rdata,
    output logic [LANES*IDX_W-1:0]   bank_ridx,
    output logic [LANES-1:0]         lane_we,
    output logic [LANES*IDX_W-1:0]   lane_idx,
    output logic [LANES*DATA_W-1:0]  lane_data
);

    localparam int ENT_W = CNT_W + $clog2(LANES + 1) + 1;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ENT_W-1:0] entry;

        // Entry number handled by this lane in the current cycle.
        always_comb begin
            entry = ENT_W'(step) * ENT_W'(LANES) + ENT_W'(j);
            lane_we[j] = (phase == PH_BANK) && (entry < ENT_W'(NREG));
            bank_ridx[j*IDX_W +: IDX_W] = entry[IDX_W-1:0];
            lane_idx[j*IDX_W +: IDX_W]  = entry[IDX_W-1:0];
            lane_data[j*DATA_W +: DATA_W] = bank_rdata[j*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/regbank_restore_seq.sv
// Register bank restore sequencer top. It joins the phase controller, the
// stack address generator and the bank copy lanes, merges their writes
// onto the register-file lanes and drives stall and the pointer update.
// Assumes: one restore at a time; memory read latency of one cycle.
module regbank_restore_seq
    import rbr_pkg::*;
#(
    parameter int  NREG    = 19,
    parameter int  BANK_EX = 9,
    parameter int  DATA_W  = 32,
    parameter int  ADDR_W  = 32,
    localparam int LANES   = (NREG + BANK_EX - 1) / BANK_EX,
    localparam int IDX_W   = $clog2(NREG),
    localparam int CNT_W   = $clog2((NREG > BANK_EX ? NREG : BANK_EX) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    mode,
    input  logic [ADDR_W-1:0]       sp_in,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic [LANES*DATA_W-1:0] bank_rdata,
    output logic [LANES*IDX_W-1:0]  bank_ridx,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES-1:0]        rf_we,
    output logic [LANES*IDX_W-1:0]  rf_waddr,
    output logic [LANES*DATA_W-1:0] rf_wdata,
    output logic                    sp_we,
    output logic [ADDR_W-1:0]       sp_wdata,
    output logic                    busy,
    output logic                    stall,
    output logic                    done
);

    phase_e             phase;
    logic [CNT_W-1:0]   step;
    logic               accept;
    logic               stk_wr_valid;
    logic [IDX_W-1:0]   stk_wr_idx;
    logic [ADDR_W-1:0]  sp_next;
    logic [LANES-1:0]        bank_we;
    logic [LANES*IDX_W-1:0]  bank_idx;
    logic [LANES*DATA_W-1:0] bank_data;

    rbr_ctrl #(
        .NREG    (NREG),
        .BANK_EX (BANK_EX),
        .CNT_W   (CNT_W)
    ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .phase  (phase),
        .step   (step),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    rbr_stack_agu #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) i_agu (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sp_in    (sp_in),
        .phase    (phase),
        .step     (step),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .wr_valid (stk_wr_valid),
        .wr_idx   (stk_wr_idx),
        .sp_next  (sp_next)
    );

    rbr_bank_copy #(
        .NREG   (NREG),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_bank (
        .phase      (phase),
        .step       (step),
        .bank_rdata (bank_rdata),
        .bank_ridx  (bank_ridx),
        .lane_we    (bank_we),
        .lane_idx   (bank_idx),
        .lane_data  (bank_data)
    );

    // Lane 0 carries either the bank copy or the popped stack word.
    always_comb begin
        rf_we    = bank_we;
        rf_waddr = bank_idx;
        rf_wdata = bank_data;
        if (stk_wr_valid) begin
            rf_we[0]            = 1'b1;
            rf_waddr[IDX_W-1:0] = stk_wr_idx;
            rf_wdata[DATA_W-1:0] = mem_rdata;
        end
    end

    // Stall and stack pointer update.
    always_comb begin
        stall    = busy;
        sp_we    = done && (phase == PH_SWB);
        sp_wdata = sp_next;
    end

    // R3: the bank path never requests memory.
    a_r3_bank_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BANK) |-> !mem_req);

    // R7: the stack path uses at most one write lane.
    a_r7_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_BANK) |-> ($countones(rf_we) <= 1));

    // R2: memory requests start only after the stack execute cycle.
    a_r2_stack_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(phase) == PH_SEXE));

    // R8: the pointer update coincides with done.
    a_r8_sp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (done && !mem_req));

    // R9: a start while busy does not disturb the step sequence.
    a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: tb/test_regbank_restore_seq.sv
module test_regbank_restore_seq;

    localparam int  CLK_PERIOD = 10;
    localparam int  NREG  = 19;
    localparam int  LANES = 3;
    localparam int  IDX_W = 5;
    localparam int  DW    = 32;
    localparam int  AW    = 32;

    typedef struct {
        int          idx;
        logic [31:0] data;
        string       req;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [AW-1:0] sp_in = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic [LANES*DW-1:0] bank_rdata;
    logic [LANES*IDX_W-1:0] bank_ridx;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic [LANES-1:0] rf_we;
    logic [LANES*IDX_W-1:0] rf_waddr;
    logic [LANES*DW-1:0] rf_wdata;
    logic sp_we;
    logic [AW-1:0] sp_wdata;
    logic busy, stall, done;

    logic [31:0] bank [NREG];
    wr_item_t    exp_q [$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;
    bit monitor_on = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_restore_seq i_regbank_restore_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sp_in(sp_in),
        .mem_rdata(mem_rdata), .bank_rdata(bank_rdata), .bank_ridx(bank_ridx),
        .mem_req(mem_req), .mem_addr(mem_addr), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sp_we(sp_we),
        .sp_wdata(sp_wdata), .busy(busy), .stall(stall), .done(done)
    );

    function automatic logic [31:0] memfn(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0F96;
    endfunction

    // Bank model: combinational read per lane.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            int e;
            e = int'(bank_ridx[j*IDX_W +: IDX_W]);
            bank_rdata[j*DW +: DW] = (e < NREG) ? bank[e] : 32'hDEAD_DEAD;
        end
    end

    // Memory model: data returns the cycle after a request.
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= memfn(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every lane write pops the next expected item.
    always @(negedge clk) begin
        if (monitor_on) begin
            for (int j = 0; j < LANES; j++) begin
                if (rf_we[j]) begin
                    int          a;
                    logic [31:0] d;
                    a = int'(rf_waddr[j*IDX_W +: IDX_W]);
                    d = rf_wdata[j*DW +: DW];
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4/R7", "unexpected write", 64'(a), 64'hFFFF);
                    end else begin
                        wr_item_t it;
                        it = exp_q.pop_front();
                        chk(a == it.idx, it.req, "write index", 64'(a), 64'(it.idx));
                        chk(d == it.data, it.req, "write data", 64'(d), 64'(it.data));
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 20000) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=%0d expected=<20000", cyc_total);
            summary();
            $finish;
        end
    end

    task automatic fill_bank(input logic [31:0] salt);
        for (int i = 0; i < NREG; i++) bank[i] = (32'hB000_0000 + 32'(i) * 32'h0001_0203) ^ salt;
    endtask

    // Driver: push expected writes, issue, then follow the sequence.
    task automatic run_restore(input bit m, input logic [31:0] sp, input bit poke);
        int cyc = 0, done_at = 0, n_done = 0, memn = 0, first_mem = 0;
        int addr_err = 0, stall_err = 0, n_spwe = 0, lane_err = 0;
        logic [31:0] sp_seen = '0;
        string rq_len;
        for (int i = 0; i < NREG; i++) begin
            wr_item_t it;
            it.idx  = i;
            it.data = m ? memfn(sp + 32'(4 * i)) : bank[i];
            it.req  = m ? "R7" : "R4";
            exp_q.push_back(it);
        end
        @(negedge clk);
        start = 1'b1; mode = m; sp_in = sp;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            cyc++;
            if (stall != busy) stall_err++;
            if (done) begin n_done++; done_at = cyc; end
            if (mem_req) begin
                if (first_mem == 0) first_mem = cyc;
                if (mem_addr != sp + 32'(4 * memn)) addr_err++;
                memn++;
            end
            if (m && rf_we[LANES-1:1] != '0) lane_err++;
            if (sp_we) begin n_spwe++; sp_seen = sp_wdata; end
            if (poke && cyc == 2) begin start = 1'b1; mode = ~m; sp_in = ~sp; end
            if (poke && cyc == 3) begin start = 1'b0; end
            if (cyc > 100) break;
            @(negedge clk);
        end
        rq_len = m ? "R5" : "R3";
        chk(cyc == (m ? 21 : 9), rq_len, "busy length", 64'(cyc), m ? 64'd21 : 64'd9);
        chk(n_done == 1 && done_at == cyc, "R11", "done pulse cycle", 64'(done_at), 64'(cyc));
        chk(memn == (m ? 19 : 0), m ? "R6" : "R3", "request count", 64'(memn), m ? 64'd19 : 64'd0);
        if (m) begin
            chk(first_mem == 2, "R6", "first request cycle", 64'(first_mem), 64'd2);
            chk(addr_err == 0, "R6", "address errors", 64'(addr_err), 64'd0);
            chk(n_spwe == 1, "R8", "sp_we pulses", 64'(n_spwe), 64'd1);
            chk(sp_seen == sp + 32'd76, "R8", "final sp", 64'(sp_seen), 64'(sp + 32'd76));
            chk(lane_err == 0, "R7", "extra lanes", 64'(lane_err), 64'd0);
        end else begin
            chk(n_spwe == 0, "R8", "sp_we in bank mode", 64'(n_spwe), 64'd0);
        end
        chk(stall_err == 0, "R9", "stall vs busy", 64'(stall_err), 64'd0);
        chk(!busy && !mem_req && rf_we == '0, "R11", "idle after done",
            64'({busy, mem_req, rf_we}), 64'd0);
        chk(exp_q.size() == 0, m ? "R7" : "R4", "writes left", 64'(exp_q.size()), 64'd0);
        if (poke) chk(1'b1, "R10", "mid-sequence mode/sp change ignored", 64'd0, 64'd0);
        exp_q.delete();
    endtask

    initial begin
        fill_bank(32'h0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !stall && !done, "R1", "reset busy/stall/done", 64'({busy, stall, done}), 64'd0);
        chk(!mem_req && !sp_we && rf_we == '0, "R1", "reset req/we",
            64'({mem_req, sp_we, rf_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4: bank restore
        run_restore(1'b0, 32'h0000_4000, 1'b0);
        // R2/R5/R6/R7/R8: stack restore
        run_restore(1'b1, 32'h0000_1000, 1'b0);
        // R9/R10: start, mode and sp disturbed while busy, both paths
        fill_bank(32'h1357_9BDF);
        run_restore(1'b0, 32'h0000_2000, 1'b1);
        run_restore(1'b1, 32'h0000_8000, 1'b1);
        // R6/R8: address wrap near the top of the space
        run_restore(1'b1, 32'hFFFF_FFF0, 1'b0);

        // R1: reset in the middle of a stack restore
        @(negedge clk);
        start = 1'b1; mode = 1'b1; sp_in = 32'h0000_3000;
        @(negedge clk);
        start = 1'b0;
        monitor_on = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R1", "abort busy/req", 64'({busy, mem_req, done}), 64'd0);
        chk(rf_we == '0 && !sp_we, "R1", "abort writes", 64'({rf_we, sp_we}), 64'd0);
        exp_q.delete();
        rst_n = 1'b1;
        monitor_on = 1'b1;
        @(negedge clk);
        // R2: a fresh bank restore after the abort
        run_restore(1'b0, 32'h0, 1'b0);

        summary();
        $finish;
    end

endmodule